// File: doc/BRIEF.md
# DMA Channel Scheduler and Element Mover

This block sits between a DMA controller's channel register file and its memory master. On every free cycle it examines all channels, picks the lowest-numbered one that may move data, and then performs exactly one element transfer for that channel. An element transfer is one read from the source address followed by one write of the same data to the destination address, both over a request/ready memory port.

A channel may move data only when it is enabled, not halted, and the global enable is set. It must also still have elements left, and its flow type must find the peripheral request lines it needs. Once the write has been accepted, the block returns the advanced addresses and the control word with its count reduced by one. The register file stores these on a one-cycle write-back strobe. When the count reaches zero, a done pulse names the channel so that the descriptor loader can take over.

Peripheral-controlled flow types are not served. A channel that selects one of them is flagged as unsupported instead.

Top module: `dma_elem_engine`

## Requirements
- R1: A channel is eligible only while the global enable is 1, its configuration bit 0 (enable) is 1, its configuration bit 18 (halt) is 0 and its control count (bits 11:0) is nonzero.
- R2: The flow type is configuration bits 13:11, the source peripheral ID is bits 5:1 and the destination peripheral ID is bits 10:6. The request vector is the OR of the single and burst request inputs, and an ID at or above REQ_W has no request. Flow 0 needs no request, flow 1 needs the destination request, flow 2 needs the source request, and flow 3 needs both.
- R3: Flow types 4 to 7 are never eligible, and `unsup_flag[c]` is 1 whenever channel c has configuration bit 0 set with such a flow type.
- R4: Among eligible channels, the lowest index is served. Each grant moves one element, and selection restarts from channel 0 after every element.
- R5: An element is a read (`mem_we`=0, address = source, `mem_size` = control bits 20:18) followed by a write (`mem_we`=1, address = destination, `mem_size` = control bits 23:21, `mem_wdata` = the data read). `mem_req` stays high, with address and direction unchanged, until `mem_ready` is seen.
- R6: After the element, the source address has advanced by 1 << (bits 20:18) bytes if control bit 26 is 1 and is otherwise unchanged. The destination address has advanced by 1 << (bits 23:21) bytes if control bit 27 is 1 and is otherwise unchanged.
- R7: The cycle after the write is accepted, `wb_valid` is high for exactly one cycle with `wb_ch`, the updated addresses, and `wb_ctrl` holding the count decremented by one and bits 31:12 unchanged.
- R8: `done_pulse` is high together with `wb_valid`, with `done_ch` equal to `wb_ch`, exactly when the written-back count is zero.
- R9: After reset, `mem_req`, `wb_valid` and `done_pulse` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| glob_en | input | 1 | Controller-wide enable |
| ch_cfg | input | N_CH*32 | Configuration word per channel, channel c at bits c*32 upward |
| ch_ctrl | input | N_CH*32 | Control word per channel |
| ch_src | input | N_CH*AW | Current source address per channel |
| ch_dst | input | N_CH*AW | Current destination address per channel |
| req_single | input | REQ_W | Single-transfer request lines by peripheral ID |
| req_burst | input | REQ_W | Burst request lines by peripheral ID |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Byte address of the access |
| mem_size | output | 3 | Access size as log2 of bytes |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid with mem_ready on a read |
| mem_ready | input | 1 | Access accepted this cycle |
| wb_valid | output | 1 | Write-back strobe for the served channel |
| wb_ch | output | CH_W | Index of the served channel |
| wb_src | output | AW | Updated source address |
| wb_dst | output | AW | Updated destination address |
| wb_ctrl | output | 32 | Updated control word |
| done_pulse | output | 1 | Count of the served channel reached zero |
| done_ch | output | CH_W | Channel whose count reached zero |
| unsup_flag | output | N_CH | Enabled channel uses an unsupported flow type |

## Verification
A wrong captured address, width code or increment bit shows on `mem_addr` or `mem_size` on the very next access, and it also shows in the write-back of that element. A wrong decrement or a corrupted upper control field shows on `wb_ctrl` no later than one cycle after the write handshake. A corrupted count also shows as a done pulse that comes too early, comes too late, or never comes. Selection faults show as the wrong `wb_ch` order when several channels are ready. Eligibility faults show as accesses appearing or missing for a given flow, request, enable and halt combination within a dozen cycles of the change.

// File: rtl/dma_elem_pkg.sv
package dma_elem_pkg;

   // configuration word fields
   localparam int CFG_EN_BIT   = 0;
   localparam int CFG_SID_LSB  = 1;
   localparam int CFG_DID_LSB  = 6;
   localparam int CFG_FLOW_LSB = 11;
   localparam int CFG_HALT_BIT = 18;
   localparam int ID_W         = 5;
   localparam int FLOW_W       = 3;

   // control word fields
   localparam int CNT_W        = 12;
   localparam int CTL_SW_LSB   = 18;
   localparam int CTL_DW_LSB   = 21;
   localparam int CTL_SINC_BIT = 26;
   localparam int CTL_DINC_BIT = 27;
   localparam int WCODE_W      = 3;

   typedef enum logic [FLOW_W-1:0] {
      FLOW_MEM_MEM = 3'd0,
      FLOW_MEM_PER = 3'd1,
      FLOW_PER_MEM = 3'd2,
      FLOW_PER_PER = 3'd3
   } flow_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ  = 2'd1,
      ST_WRITE = 2'd2,
      ST_WBACK = 2'd3
   } mover_st_e;

endpackage

// File: rtl/dma_chan_elig.sv
module dma_chan_elig
   import dma_elem_pkg::*;
#(
   parameter int REQ_W = 16
) (
   input  logic             glob_en,
   input  logic [31:0]      cfg,
   input  logic [31:0]      ctrl,
   input  logic [REQ_W-1:0] req,
   output logic             elig,
   output logic             unsup
);

   logic [FLOW_W-1:0] flow;
   logic [ID_W-1:0]   sid;
   logic [ID_W-1:0]   did;
   logic [31:0]       req_ext;
   logic              sreq;
   logic              dreq;
   logic              flow_ok;
   logic              base_ok;

   assign flow = cfg[CFG_FLOW_LSB +: FLOW_W];
   assign sid  = cfg[CFG_SID_LSB +: ID_W];
   assign did  = cfg[CFG_DID_LSB +: ID_W];

   // IDs beyond the implemented request lines read as idle
   always_comb begin
      req_ext = '0;
      req_ext[REQ_W-1:0] = req;
   end

   assign sreq = req_ext[sid];
   assign dreq = req_ext[did];

   always_comb begin
      case (flow)
         FLOW_MEM_MEM: flow_ok = 1'b1;
         FLOW_MEM_PER: flow_ok = dreq;
         FLOW_PER_MEM: flow_ok = sreq;
         FLOW_PER_PER: flow_ok = sreq & dreq;
         default:      flow_ok = 1'b0;
      endcase
   end

   assign base_ok = glob_en & cfg[CFG_EN_BIT] & ~cfg[CFG_HALT_BIT]
                  & (ctrl[CNT_W-1:0] != '0);
   assign elig    = base_ok & flow_ok;
   assign unsup   = cfg[CFG_EN_BIT] & flow[FLOW_W-1];

endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
   parameter int N_CH = 4,
   localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
   input  logic [N_CH-1:0] elig,
   output logic [N_CH-1:0] grant,
   output logic [CH_W-1:0] idx,
   output logic            any
);

   logic [N_CH-1:0] below;

   for (genvar i = 0; i < N_CH; i++) begin : g_lane
      if (i == 0) begin : g_first
         assign below[i] = 1'b0;
      end else begin : g_rest
         assign below[i] = below[i-1] | elig[i-1];
      end
      assign grant[i] = elig[i] & ~below[i];
   end

   always_comb begin
      idx = '0;
      for (int i = 0; i < N_CH; i++) begin
         if (grant[i]) idx = CH_W'(i);
      end
   end

   assign any = |elig;

endmodule

// File: rtl/dma_elem_mover.sv
module dma_elem_mover
   import dma_elem_pkg::*;
#(
   parameter int AW   = 32,
   parameter int DW   = 32,
   parameter int CH_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [CH_W-1:0] start_ch,
   input  logic [AW-1:0]   src_in,
   input  logic [AW-1:0]   dst_in,
   input  logic [31:0]     ctrl_in,
   output logic            busy,
   output logic            mem_req,
   output logic            mem_we,
   output logic [AW-1:0]   mem_addr,
   output logic [2:0]      mem_size,
   output logic [DW-1:0]   mem_wdata,
   input  logic [DW-1:0]   mem_rdata,
   input  logic            mem_ready,
   output logic            wb_valid,
   output logic [CH_W-1:0] wb_ch,
   output logic [AW-1:0]   wb_src,
   output logic [AW-1:0]   wb_dst,
   output logic [31:0]     wb_ctrl,
   output logic            done_pulse,
   output logic [CH_W-1:0] done_ch
);

   mover_st_e          st_q;
   logic [CH_W-1:0]    ch_q;
   logic [AW-1:0]      src_q;
   logic [AW-1:0]      dst_q;
   logic [31:0]        ctrl_q;
   logic [DW-1:0]      data_q;
   logic [WCODE_W-1:0] scode;
   logic [WCODE_W-1:0] dcode;
   logic [AW-1:0]      sstep;
   logic [AW-1:0]      dstep;

   assign scode = ctrl_q[CTL_SW_LSB +: WCODE_W];
   assign dcode = ctrl_q[CTL_DW_LSB +: WCODE_W];
   assign sstep = ctrl_q[CTL_SINC_BIT] ? (AW'(1) << scode) : '0;
   assign dstep = ctrl_q[CTL_DINC_BIT] ? (AW'(1) << dcode) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         ch_q   <= '0;
         src_q  <= '0;
         dst_q  <= '0;
         ctrl_q <= '0;
         data_q <= '0;
      end else begin
         case (st_q)
            ST_IDLE: if (start) begin
               ch_q   <= start_ch;
               src_q  <= src_in;
               dst_q  <= dst_in;
               ctrl_q <= ctrl_in;
               st_q   <= ST_READ;
            end
            ST_READ: if (mem_ready) begin
               data_q <= mem_rdata;
               st_q   <= ST_WRITE;
            end
            ST_WRITE: if (mem_ready) begin
               src_q  <= src_q + sstep;
               dst_q  <= dst_q + dstep;
               ctrl_q[CNT_W-1:0] <= ctrl_q[CNT_W-1:0] - 1'b1;
               st_q   <= ST_WBACK;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign busy       = (st_q != ST_IDLE);
   assign mem_req    = (st_q == ST_READ) || (st_q == ST_WRITE);
   assign mem_we     = (st_q == ST_WRITE);
   assign mem_addr   = mem_we ? dst_q : src_q;
   assign mem_size   = mem_we ? dcode : scode;
   assign mem_wdata  = data_q;
   assign wb_valid   = (st_q == ST_WBACK);
   assign wb_ch      = ch_q;
   assign wb_src     = src_q;
   assign wb_dst     = dst_q;
   assign wb_ctrl    = ctrl_q;
   assign done_pulse = wb_valid && (ctrl_q[CNT_W-1:0] == '0);
   assign done_ch    = ch_q;

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)) // R5
      else $error("request dropped or changed before ready");

   AST_WB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |=> !wb_valid) // R7
      else $error("write-back strobe longer than one cycle");

   AST_WB_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wb_valid) |-> $past(mem_req && mem_we && mem_ready)) // R7
      else $error("write-back without accepted write");

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mem_req) // R9
      else $error("memory request while idle");

endmodule

// File: rtl/dma_elem_engine.sv
module dma_elem_engine
   import dma_elem_pkg::*;
#(
   parameter int N_CH  = 4,
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int REQ_W = 16,
   localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              glob_en,
   input  logic [N_CH*32-1:0] ch_cfg,
   input  logic [N_CH*32-1:0] ch_ctrl,
   input  logic [N_CH*AW-1:0] ch_src,
   input  logic [N_CH*AW-1:0] ch_dst,
   input  logic [REQ_W-1:0]  req_single,
   input  logic [REQ_W-1:0]  req_burst,
   output logic              mem_req,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [2:0]        mem_size,
   output logic [DW-1:0]     mem_wdata,
   input  logic [DW-1:0]     mem_rdata,
   input  logic              mem_ready,
   output logic              wb_valid,
   output logic [CH_W-1:0]   wb_ch,
   output logic [AW-1:0]     wb_src,
   output logic [AW-1:0]     wb_dst,
   output logic [31:0]       wb_ctrl,
   output logic              done_pulse,
   output logic [CH_W-1:0]   done_ch,
   output logic [N_CH-1:0]   unsup_flag
);

   initial begin
      assert (N_CH >= 1 && N_CH <= 32) else $error("N_CH out of range");
      assert (REQ_W >= 1 && REQ_W <= 32) else $error("REQ_W out of range");
      assert (DW >= 8) else $error("DW too narrow");
      assert (AW >= 8) else $error("AW too narrow");
   end

   logic [REQ_W-1:0] req_any;
   logic [N_CH-1:0]  elig;
   logic [N_CH-1:0]  grant;
   logic [CH_W-1:0]  pick_idx;
   logic             pick_any;
   logic             busy;
   logic             start;

   assign req_any = req_single | req_burst;

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      dma_chan_elig #(.REQ_W(REQ_W)) elig_i (
         .glob_en (glob_en),
         .cfg     (ch_cfg[c*32 +: 32]),
         .ctrl    (ch_ctrl[c*32 +: 32]),
         .req     (req_any),
         .elig    (elig[c]),
         .unsup   (unsup_flag[c])
      );
   end

   dma_prio_pick #(.N_CH(N_CH)) pick_i (
      .elig  (elig),
      .grant (grant),
      .idx   (pick_idx),
      .any   (pick_any)
   );

   assign start = pick_any & ~busy;

   dma_elem_mover #(.AW(AW), .DW(DW), .CH_W(CH_W)) mover_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .start_ch   (pick_idx),
      .src_in     (ch_src[pick_idx*AW +: AW]),
      .dst_in     (ch_dst[pick_idx*AW +: AW]),
      .ctrl_in    (ch_ctrl[pick_idx*32 +: 32]),
      .busy       (busy),
      .mem_req    (mem_req),
      .mem_we     (mem_we),
      .mem_addr   (mem_addr),
      .mem_size   (mem_size),
      .mem_wdata  (mem_wdata),
      .mem_rdata  (mem_rdata),
      .mem_ready  (mem_ready),
      .wb_valid   (wb_valid),
      .wb_ch      (wb_ch),
      .wb_src     (wb_src),
      .wb_dst     (wb_dst),
      .wb_ctrl    (wb_ctrl),
      .done_pulse (done_pulse),
      .done_ch    (done_ch)
   );

   AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant)) // R4
      else $error("more than one channel granted");

   AST_NO_UNSUP_SERVE: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !unsup_flag[pick_idx]) // R3
      else $error("unsupported flow channel started");

   AST_DONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse |-> wb_valid && (done_ch == wb_ch)) // R8
      else $error("done pulse not aligned with write-back");

endmodule

// File: tb/dma_elem_engine_tb.sv
module dma_elem_engine_tb_top;

   localparam int CLK_P = 10;
   localparam int N_CH  = 4;
   localparam int AW    = 32;
   localparam int DW    = 32;
   localparam int REQ_W = 16;
   localparam int CH_W  = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_P/2) clk = ~clk;

   // host-side images written only by the stimulus process
   logic [31:0] h_cfg [N_CH];
   logic [31:0] h_ctrl[N_CH];
   logic [31:0] h_src [N_CH];
   logic [31:0] h_dst [N_CH];
   // register file images written only by the clocked process
   logic [31:0] r_cfg [N_CH];
   logic [31:0] r_ctrl[N_CH];
   logic [31:0] r_src [N_CH];
   logic [31:0] r_dst [N_CH];

   logic             h_gen = 1'b0;
   logic [REQ_W-1:0] h_sreq = '0;
   logic [REQ_W-1:0] h_breq = '0;
   logic             ld = 1'b1;
   logic             clr = 1'b1;
   int               lat = 1;

   logic [N_CH*32-1:0] ch_cfg, ch_ctrl, ch_src, ch_dst;
   logic mem_req, mem_we, mem_ready, wb_valid, done_pulse;
   logic [AW-1:0] mem_addr, wb_src, wb_dst;
   logic [2:0] mem_size;
   logic [DW-1:0] mem_wdata, mem_rdata;
   logic [31:0] wb_ctrl;
   logic [CH_W-1:0] wb_ch, done_ch;
   logic [N_CH-1:0] unsup_flag;

   for (genvar c = 0; c < N_CH; c++) begin : g_pack
      assign ch_cfg[c*32 +: 32]  = r_cfg[c];
      assign ch_ctrl[c*32 +: 32] = r_ctrl[c];
      assign ch_src[c*32 +: 32]  = r_src[c];
      assign ch_dst[c*32 +: 32]  = r_dst[c];
   end

   dma_elem_engine #(.N_CH(N_CH), .AW(AW), .DW(DW), .REQ_W(REQ_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .glob_en(h_gen),
      .ch_cfg(ch_cfg), .ch_ctrl(ch_ctrl), .ch_src(ch_src), .ch_dst(ch_dst),
      .req_single(h_sreq), .req_burst(h_breq),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
      .wb_valid(wb_valid), .wb_ch(wb_ch), .wb_src(wb_src), .wb_dst(wb_dst),
      .wb_ctrl(wb_ctrl), .done_pulse(done_pulse), .done_ch(done_ch),
      .unsup_flag(unsup_flag)
   );

   function automatic logic [31:0] mem_pat(input logic [31:0] a);
      return a ^ 32'h5A5A_A5A5;
   endfunction

   // memory model with programmable wait
   int wait_cnt = 0;
   assign mem_ready = mem_req && (wait_cnt >= lat);
   assign mem_rdata = mem_pat(mem_addr);

   // logs
   logic [31:0] la [32];
   logic        lw [32];
   logic [2:0]  ls [32];
   logic [31:0] lwd[32];
   logic [CH_W-1:0] wbl[32];
   int ln = 0, wn = 0, dn = 0;
   logic [CH_W-1:0] dlast = '0;

   always @(posedge clk) begin
      wait_cnt <= (mem_req && !mem_ready) ? wait_cnt + 1 : 0;
      if (ld) begin
         for (int c = 0; c < N_CH; c++) begin
            r_cfg[c] <= h_cfg[c]; r_ctrl[c] <= h_ctrl[c];
            r_src[c] <= h_src[c]; r_dst[c] <= h_dst[c];
         end
      end else if (wb_valid) begin
         r_src[wb_ch] <= wb_src; r_dst[wb_ch] <= wb_dst; r_ctrl[wb_ch] <= wb_ctrl;
      end
      if (clr) begin
         ln <= 0; wn <= 0; dn <= 0;
      end else begin
         if (mem_req && mem_ready && ln < 32) begin
            la[ln] <= mem_addr; lw[ln] <= mem_we; ls[ln] <= mem_size; lwd[ln] <= mem_wdata;
            ln <= ln + 1;
         end
         if (wb_valid && wn < 32) begin
            wbl[wn] <= wb_ch; wn <= wn + 1;
         end
         if (done_pulse) begin
            dn <= dn + 1; dlast <= done_ch;
         end
      end
   end

   int n_chk = 0, n_err = 0;
   bit finished = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic clear_host();
      for (int c = 0; c < N_CH; c++) begin
         h_cfg[c] = '0; h_ctrl[c] = '0; h_src[c] = '0; h_dst[c] = '0;
      end
      h_sreq = '0; h_breq = '0;
   endtask

   task automatic load();
      @(negedge clk); ld = 1'b1; clr = 1'b1;
      @(negedge clk); ld = 1'b0; clr = 1'b0;
   endtask

   task automatic run(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(CLK_P*150000);
      if (!finished) begin
         n_chk++; n_err++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      clear_host();
      run(5);
      rst_n = 1'b1;
      ld = 1'b0; clr = 1'b0;
      @(negedge clk);
      // R9 reset state
      chk("R9 mem_req after reset", 32'(mem_req), 0);
      chk("R9 wb_valid after reset", 32'(wb_valid), 0);
      chk("R9 done_pulse after reset", 32'(done_pulse), 0);

      // R2 / R3: flow type against request presence sweep
      lat = 1;
      for (int f = 0; f < 8; f++) begin
         for (int s = 0; s < 2; s++) begin
            for (int d = 0; d < 2; d++) begin
               int ex;
               clear_host();
               h_gen = 1'b1;
               h_cfg[0]  = (32'(f) << 11) | (32'd9 << 6) | (32'd3 << 1) | 32'd1;
               h_ctrl[0] = 32'h0C48_0001;
               h_src[0]  = 32'h40; h_dst[0] = 32'h80;
               h_sreq = (s != 0) ? 16'h0008 : 16'h0;
               h_breq = (d != 0) ? 16'h0200 : 16'h0;
               load();
               chk($sformatf("R3 unsup flow=%0d", f), 32'(unsup_flag[0]), (f >= 4) ? 1 : 0);
               run(16);
               ex = (f == 0 || (f == 1 && d != 0) || (f == 2 && s != 0) ||
                     (f == 3 && s != 0 && d != 0)) ? 1 : 0;
               chk($sformatf("R2 accesses flow=%0d s=%0d d=%0d", f, s, d), 32'(ln), 32'(2*ex));
               chk($sformatf("R8 done flow=%0d s=%0d d=%0d", f, s, d), 32'(dn), 32'(ex));
            end
         end
      end

      // R2: ID above REQ_W has no request line
      clear_host(); h_gen = 1'b1;
      h_cfg[0] = (32'd2 << 11) | (32'd20 << 1) | 32'd1;
      h_ctrl[0] = 32'h0000_0001;
      h_sreq = 16'hFFFF; h_breq = 16'hFFFF;
      load(); run(16);
      chk("R2 out-of-range source ID", 32'(ln), 0);

      // R1: enable, halt, global enable and count sweep
      for (int k = 0; k < 16; k++) begin
         bit en, hl, ge, cn;
         en = k[0]; hl = k[1]; ge = k[2]; cn = k[3];
         clear_host();
         h_gen = ge;
         h_cfg[2]  = (hl ? 32'h0004_0000 : 32'h0) | (en ? 32'h1 : 32'h0);
         h_ctrl[2] = cn ? 32'h0000_0001 : 32'h0;
         load(); run(16);
         chk($sformatf("R1 en=%0d halt=%0d gen=%0d cnt=%0d", en, hl, ge, cn),
             32'(wn), (en && !hl && ge && cn) ? 1 : 0);
      end

      // R4: fixed priority, one element per grant
      clear_host(); h_gen = 1'b1; lat = 0;
      h_cfg[0] = 32'h1; h_cfg[2] = 32'h1; h_cfg[3] = 32'h1;
      h_ctrl[0] = 32'h0C48_0002; h_ctrl[2] = 32'h0C48_0002; h_ctrl[3] = 32'h0C48_0002;
      load(); run(60);
      chk("R4 element count", 32'(wn), 6);
      chk("R4 order 0", 32'(wbl[0]), 0); chk("R4 order 1", 32'(wbl[1]), 0);
      chk("R4 order 2", 32'(wbl[2]), 2); chk("R4 order 3", 32'(wbl[3]), 2);
      chk("R4 order 4", 32'(wbl[4]), 3); chk("R4 order 5", 32'(wbl[5]), 3);

      // R4 / R2: a waiting low channel does not block a ready higher one
      clear_host(); h_gen = 1'b1; lat = 1;
      h_cfg[0] = (32'd2 << 11) | (32'd4 << 1) | 32'd1; h_ctrl[0] = 32'h1;
      h_cfg[2] = 32'h1; h_ctrl[2] = 32'h1;
      load(); run(16);
      chk("R4 served while ch0 waits", 32'(wn), 1);
      chk("R4 served channel", 32'(wbl[0]), 2);
      @(negedge clk); h_breq = 16'h0010;
      run(16);
      chk("R2 burst request releases ch0", 32'(wn), 2);
      chk("R2 ch0 served", 32'(wbl[1]), 0);
      chk("R7 ch0 count zero", r_ctrl[0], 32'h0);

      // R5 / R6 / R7 / R8: width and increment sweep
      for (int sc = 0; sc < 3; sc++) begin
         for (int dc = 0; dc < 3; dc++) begin
            for (int ic = 0; ic < 4; ic++) begin
               logic [31:0] ctl, sstep, dstep;
               clear_host(); h_gen = 1'b1; lat = (sc + dc) % 3;
               ctl = 32'h9000_0000 | (32'(ic) << 26) | (32'(dc) << 21) | (32'(sc) << 18) | 32'd2;
               sstep = ic[0] ? (32'd1 << sc) : 32'd0;
               dstep = ic[1] ? (32'd1 << dc) : 32'd0;
               h_cfg[1] = 32'h1; h_ctrl[1] = ctl;
               h_src[1] = 32'h100; h_dst[1] = 32'h800;
               load(); run(24);
               chk("R5 access count", 32'(ln), 4);
               chk("R5 read0 addr", la[0], 32'h100);
               chk("R5 read0 dir", 32'(lw[0]), 0);
               chk("R5 read0 size", 32'(ls[0]), 32'(sc));
               chk("R5 write0 addr", la[1], 32'h800);
               chk("R5 write0 dir", 32'(lw[1]), 1);
               chk("R5 write0 size", 32'(ls[1]), 32'(dc));
               chk("R5 write0 data", lwd[1], mem_pat(32'h100));
               chk("R6 read1 addr", la[2], 32'h100 + sstep);
               chk("R6 write1 addr", la[3], 32'h800 + dstep);
               chk("R5 write1 data", lwd[3], mem_pat(32'h100 + sstep));
               chk("R6 final src", r_src[1], 32'h100 + 2*sstep);
               chk("R6 final dst", r_dst[1], 32'h800 + 2*dstep);
               chk("R7 final ctrl", r_ctrl[1], ctl & 32'hFFFF_F000);
               chk("R8 done count", 32'(dn), 1);
               chk("R8 done channel", 32'(dlast), 1);
            end
         end
      end

      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule